// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands. Each operand has a sign bit, an 8-bit biased exponent and a 23-bit fraction. A new operand pair can enter on every clock, marked by a valid strobe. The product leaves, with its own valid strobe, a fixed three cycles later. Three flags travel with the product: overflow, underflow and invalid.

The work is split into three register stages.
- Stage one classifies both operands, forms the result sign and computes the result exponent. This exponent is the sum of the biased exponents less one bias.
- Stage two multiplies the two 24-bit significands, each with its implicit leading one restored.
- Stage three shifts the product by at most one place, rounds to nearest with ties to even, adjusts again if rounding carries out, range-checks the exponent and packs the result.

Infinities and NaNs are handled. Operands with a zero exponent field are treated as zero.

Top module: `fp32_mul_pipe`

## Requirements
- R1: Every operand pair accepted with `in_valid` high produces exactly one result, with `out_valid` high, exactly 3 clock cycles later. Pairs may be presented on consecutive cycles.
- R2: `out_valid` is low during and after reset until a result is due, and it is never high without a pair accepted 3 cycles earlier.
- R3: For any result that is not a NaN, the sign bit (bit 31) is the XOR of the two operand sign bits.
- R4: For two normal operands, the result exponent field (bits 30:23) is ea + eb - 127, plus one when the 48-bit significand product is 2.0 or more. The fraction field (bits 22:0) holds the normalized product bits below the leading one.
- R5: The dropped product bits round the fraction to nearest, with ties to even. When rounding carries out of the fraction, the fraction becomes zero and the exponent increases by one.
- R6: If the final exponent exceeds 254, the result is an infinity with the sign of R3 (exponent field 0xFF, fraction 0) and `out_ovf` is set.
- R7: If the final exponent is below 1, the result is a zero with the sign of R3 (bits 30:0 all zero) and `out_unf` is set.
- R8: Infinity times zero, in either order, gives 0x7FC00000 with `out_inv` set.
- R9: If either operand is a NaN (exponent field 0xFF, fraction nonzero), the result is 0x7FC00000 with no flag set.
- R10: An operand whose exponent field is 0x00 is a zero whatever its fraction. Zero times a finite value gives a signed zero with no flag set.
- R11: Infinity (exponent field 0xFF, fraction 0) times a nonzero non-NaN value gives a signed infinity with no flag set.
- R12: At most one flag is set per result, and no result has exponent field 0x00 with a nonzero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand pair present on this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present on this cycle |
| out_prod | output | 32 | Product |
| out_ovf | output | 1 | Result exponent too large; infinity returned |
| out_unf | output | 1 | Result exponent too small; zero returned |
| out_inv | output | 1 | Infinity times zero; quiet NaN returned |

## Verification
Every result, together with its three flags, is due on the third rising edge after the edge that accepted its operands. The bench therefore queues each expected result tagged with the bench cycle number at which it must appear (drive cycle plus 3). The outputs are sampled on the falling edge of every cycle. When the head entry is due, `out_valid` must be high and the product and flags must match. On every other cycle `out_valid` must be low, so a result that arrives one cycle early or late fails, and so does one that is lost or duplicated.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Outcome class decided in the first stage and carried down the pipe
  typedef enum logic [2:0] {
    SPC_NONE    = 3'd0,
    SPC_ZERO    = 3'd1,
    SPC_INF     = 3'd2,
    SPC_NAN     = 3'd3,
    SPC_INVALID = 3'd4
  } spc_e;

endpackage

// File: rtl/fpm_prep.sv
module fpm_prep
  import fpm_pkg::*;
#(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int ESUM_W = EXP_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [W-1:0]             op_a,
  input  logic [W-1:0]             op_b,
  output logic                     s1_valid,
  output logic                     s1_sign,
  output logic signed [ESUM_W-1:0] s1_exp,
  output logic [SIG_W-1:0]         s1_sig_a,
  output logic [SIG_W-1:0]         s1_sig_b,
  output spc_e                     s1_spc
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [ESUM_W-1:0] BIAS_S = ESUM_W'(BIAS);

  logic [W-1:0]     ops    [2];
  logic             is_zero[2];
  logic             is_inf [2];
  logic             is_nan [2];
  logic [SIG_W-1:0] sig    [2];
  logic [EXP_W-1:0] efld   [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    logic [FRAC_W-1:0] frac;
    assign efld[i]    = ops[i][W-2 -: EXP_W];
    assign frac       = ops[i][FRAC_W-1:0];
    assign is_zero[i] = (efld[i] == '0);
    assign is_inf[i]  = (efld[i] == '1) && (frac == '0);
    assign is_nan[i]  = (efld[i] == '1) && (frac != '0);
    assign sig[i]     = {1'b1, frac};
  end

  logic                     sign_n;
  logic signed [ESUM_W-1:0] exp_n;
  spc_e                     spc_n;

  always_comb begin
    sign_n = op_a[W-1] ^ op_b[W-1];
    exp_n  = $signed({2'b00, efld[0]}) + $signed({2'b00, efld[1]}) - BIAS_S;
    if (is_nan[0] || is_nan[1])
      spc_n = SPC_NAN;
    else if ((is_inf[0] && is_zero[1]) || (is_zero[0] && is_inf[1]))
      spc_n = SPC_INVALID;
    else if (is_inf[0] || is_inf[1])
      spc_n = SPC_INF;
    else if (is_zero[0] || is_zero[1])
      spc_n = SPC_ZERO;
    else
      spc_n = SPC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_sign  <= sign_n;
      s1_exp   <= exp_n;
      s1_sig_a <= sig[0];
      s1_sig_b <= sig[1];
      s1_spc   <= spc_n;
    end
  end

endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul
  import fpm_pkg::*;
#(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int ESUM_W = EXP_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid,
  input  logic                     s1_sign,
  input  logic signed [ESUM_W-1:0] s1_exp,
  input  logic [SIG_W-1:0]         s1_sig_a,
  input  logic [SIG_W-1:0]         s1_sig_b,
  input  spc_e                     s1_spc,
  output logic                     s2_valid,
  output logic                     s2_sign,
  output logic signed [ESUM_W-1:0] s2_exp,
  output logic [PROD_W-1:0]        s2_prod,
  output spc_e                     s2_spc
);

  logic [PROD_W-1:0] prod_n;

  always_comb begin
    prod_n = PROD_W'(s1_sig_a) * PROD_W'(s1_sig_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_sign <= s1_sign;
      s2_exp  <= s1_exp;
      s2_prod <= prod_n;
      s2_spc  <= s1_spc;
    end
  end

endmodule

// File: rtl/fpm_rndpack.sv
module fpm_rndpack
  import fpm_pkg::*;
#(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int ESUM_W = EXP_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s2_valid,
  input  logic                     s2_sign,
  input  logic signed [ESUM_W-1:0] s2_exp,
  input  logic [PROD_W-1:0]        s2_prod,
  input  spc_e                     s2_spc,
  output logic                     out_valid,
  output logic [W-1:0]             out_prod,
  output logic                     out_ovf,
  output logic                     out_unf,
  output logic                     out_inv
);

  localparam int EMAX = (1 << EXP_W) - 2;
  localparam logic signed [ESUM_W-1:0] EMAX_S = ESUM_W'(EMAX);
  localparam logic signed [ESUM_W-1:0] EMIN_S = ESUM_W'(1);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic                     hi;
  logic [FRAC_W-1:0]        mant_pre;
  logic                     guard;
  logic                     sticky;
  logic                     rnd_up;
  logic                     carry;
  logic [FRAC_W-1:0]        mant_r;
  logic signed [ESUM_W-1:0] exp_n;
  logic signed [ESUM_W-1:0] exp_r;
  logic [W-1:0]             res_n;
  logic                     ovf_n, unf_n, inv_n;

  always_comb begin
    // normalize: at most a single place, product lies in [1,4)
    hi       = s2_prod[PROD_W-1];
    mant_pre = hi ? s2_prod[PROD_W-2 -: FRAC_W] : s2_prod[PROD_W-3 -: FRAC_W];
    guard    = hi ? s2_prod[PROD_W-2-FRAC_W] : s2_prod[PROD_W-3-FRAC_W];
    sticky   = (|s2_prod[PROD_W-4-FRAC_W:0]) | (hi & s2_prod[PROD_W-3-FRAC_W]);
    exp_n    = s2_exp + {{(ESUM_W-1){1'b0}}, hi};
    // nearest, ties to even
    rnd_up          = guard & (sticky | mant_pre[0]);
    {carry, mant_r} = {1'b0, mant_pre} + {{FRAC_W{1'b0}}, rnd_up};
    exp_r           = exp_n + {{(ESUM_W-1){1'b0}}, carry};

    ovf_n = 1'b0;
    unf_n = 1'b0;
    inv_n = 1'b0;
    unique case (s2_spc)
      SPC_NAN:     res_n = QNAN;
      SPC_INVALID: begin
        res_n = QNAN;
        inv_n = 1'b1;
      end
      SPC_INF:     res_n = {s2_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      SPC_ZERO:    res_n = {s2_sign, {(W-1){1'b0}}};
      default: begin
        if (exp_r > EMAX_S) begin
          res_n = {s2_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          ovf_n = 1'b1;
        end else if (exp_r < EMIN_S) begin
          res_n = {s2_sign, {(W-1){1'b0}}};
          unf_n = 1'b1;
        end else begin
          res_n = {s2_sign, exp_r[EXP_W-1:0], mant_r};
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s2_valid;
  end

  always_ff @(posedge clk) begin
    if (s2_valid) begin
      out_prod <= res_n;
      out_ovf  <= ovf_n;
      out_unf  <= unf_n;
      out_inv  <= inv_n;
    end
  end

endmodule

// File: rtl/fp32_mul_pipe.sv
module fp32_mul_pipe
  import fpm_pkg::*;
#(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int ESUM_W = EXP_W + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [W-1:0] out_prod,
  output logic         out_ovf,
  output logic         out_unf,
  output logic         out_inv
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic                     s1_valid, s1_sign;
  logic signed [ESUM_W-1:0] s1_exp;
  logic [SIG_W-1:0]         s1_sig_a, s1_sig_b;
  spc_e                     s1_spc;

  logic                     s2_valid, s2_sign;
  logic signed [ESUM_W-1:0] s2_exp;
  logic [PROD_W-1:0]        s2_prod;
  spc_e                     s2_spc;

  fpm_prep #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_prep (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .s1_valid (s1_valid),
    .s1_sign  (s1_sign),
    .s1_exp   (s1_exp),
    .s1_sig_a (s1_sig_a),
    .s1_sig_b (s1_sig_b),
    .s1_spc   (s1_spc)
  );

  fpm_sigmul #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sigmul (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .s1_valid (s1_valid),
    .s1_sign  (s1_sign),
    .s1_exp   (s1_exp),
    .s1_sig_a (s1_sig_a),
    .s1_sig_b (s1_sig_b),
    .s1_spc   (s1_spc),
    .s2_valid (s2_valid),
    .s2_sign  (s2_sign),
    .s2_exp   (s2_exp),
    .s2_prod  (s2_prod),
    .s2_spc   (s2_spc)
  );

  fpm_rndpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rndpack (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .s2_valid  (s2_valid),
    .s2_sign   (s2_sign),
    .s2_exp    (s2_exp),
    .s2_prod   (s2_prod),
    .s2_spc    (s2_spc),
    .out_valid (out_valid),
    .out_prod  (out_prod),
    .out_ovf   (out_ovf),
    .out_unf   (out_unf),
    .out_inv   (out_inv)
  );

endmodule

// File: rtl/fpm_mul_checker.sv
module fpm_mul_checker #(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_ok_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         out_valid,
  input logic [W-1:0] out_prod,
  input logic         out_ovf,
  input logic         out_unf,
  input logic         out_inv
);

  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic res_is_nan;
  assign res_is_nan = (out_prod[W-2 -: EXP_W] == '1) && (out_prod[FRAC_W-1:0] != '0);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_ok_n)
    in_valid |-> ##3 out_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    out_valid |-> $past(in_valid, 3));

  assert_sign_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (out_valid && !res_is_nan) |-> (out_prod[W-1] == $past(op_a[W-1] ^ op_b[W-1], 3)));

  assert_ovf_inf_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (out_valid && out_ovf) |-> (out_prod[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  assert_unf_zero_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (out_valid && out_unf) |-> (out_prod[W-2:0] == '0));

  assert_inv_nan_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (out_valid && out_inv) |-> (out_prod == QNAN));

  assert_flags_onehot_R12: assert property (@(posedge clk) disable iff (!rst_ok_n)
    out_valid |-> $onehot0({out_ovf, out_unf, out_inv}));

  assert_no_subnormal_R12: assert property (@(posedge clk) disable iff (!rst_ok_n)
    out_valid |-> !((out_prod[W-2 -: EXP_W] == '0) && (out_prod[FRAC_W-1:0] != '0)));

endmodule

bind fp32_mul_pipe fpm_mul_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_ok_n  (rst_sync_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .out_prod  (out_prod),
  .out_ovf   (out_ovf),
  .out_unf   (out_unf),
  .out_inv   (out_inv)
);

// File: tb/fp32_mul_pipe_tb_top.sv
module fp32_mul_pipe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid;
  logic [31:0] out_prod;
  logic        out_ovf, out_unf, out_inv;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  typedef struct packed {
    int          due;
    logic [31:0] res;
    logic [2:0]  flg;   // {inv, unf, ovf}
    logic [3:0]  tag;
    logic        chk_sign;
    logic        sgn;
  } exp_t;

  exp_t q[$];

  fp32_mul_pipe dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .out_prod  (out_prod),
    .out_ovf   (out_ovf),
    .out_unf   (out_unf),
    .out_inv   (out_inv)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  // behavioural reference: arithmetic on wide integers
  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b);
    exp_t r;
    int   ea, eb, e, shift;
    longint unsigned fa, fb, p, m, rem, half;
    logic s, za, zb, ia, ib, na, nb;
    r = '0;
    s  = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    fa = longint'(a[22:0]);
    fb = longint'(b[22:0]);
    za = (ea == 0);   zb = (eb == 0);
    ia = (ea == 255) && (fa == 0);  ib = (eb == 255) && (fb == 0);
    na = (ea == 255) && (fa != 0);  nb = (eb == 255) && (fb != 0);
    r.chk_sign = 1'b1;
    r.sgn      = s;
    if (na || nb) begin
      r.res = 32'h7FC0_0000; r.tag = 4'd9; r.chk_sign = 1'b0;
    end else if ((ia && zb) || (za && ib)) begin
      r.res = 32'h7FC0_0000; r.flg = 3'b100; r.tag = 4'd8; r.chk_sign = 1'b0;
    end else if (ia || ib) begin
      r.res = {s, 8'hFF, 23'd0}; r.tag = 4'd11;
    end else if (za || zb) begin
      r.res = {s, 31'd0}; r.tag = 4'd10;
    end else begin
      p = ((64'd1 << 23) + fa) * ((64'd1 << 23) + fb);
      e = ea + eb - 127;
      if (p >= (64'd1 << 47)) begin shift = 24; e = e + 1; end
      else shift = 23;
      m    = p >> shift;
      rem  = p - (m << shift);
      half = 64'd1 << (shift - 1);
      if (rem > half || (rem == half && m[0])) m = m + 1;
      if (m == (64'd1 << 24)) begin m = m >> 1; e = e + 1; end
      r.tag = (rem != 0) ? 4'd5 : 4'd4;
      if (e > 254) begin
        r.res = {s, 8'hFF, 23'd0}; r.flg = 3'b001; r.tag = 4'd6;
      end else if (e < 1) begin
        r.res = {s, 31'd0}; r.flg = 3'b010; r.tag = 4'd7;
      end else begin
        r.res = {s, 8'(e), m[22:0]};
      end
    end
    return r;
  endfunction

  task automatic note_fail(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] expv);
    n_fails++;
    $display("FAIL %s %s actual=%08h expected=%08h (cycle %0d)", req, what, act, expv, cyc);
  endtask

  // output comparison on every falling edge
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0 && q[0].due == cyc) begin
      e = q.pop_front();
      n_checks++;
      if (out_valid !== 1'b1) note_fail("R1", "out_valid", 32'(out_valid), 32'd1);
      n_checks++;
      if (out_prod !== e.res || {out_inv, out_unf, out_ovf} !== e.flg) begin
        note_fail(tag_name(e.tag), "product", out_prod, e.res);
        $display("      flags {inv,unf,ovf} actual=%b expected=%b", {out_inv, out_unf, out_ovf}, e.flg);
      end
      if (e.chk_sign) begin
        n_checks++;
        if (out_prod[31] !== e.sgn) note_fail("R3", "sign", 32'(out_prod[31]), 32'(e.sgn));
      end
      n_checks++;
      if ($countones({out_inv, out_unf, out_ovf}) > 1 ||
          (out_prod[30:23] == 8'd0 && out_prod[22:0] != 23'd0))
        note_fail("R12", "flags/encoding", out_prod, e.res);
    end else begin
      n_checks++;
      if (out_valid !== 1'b0) note_fail("R2", "out_valid", 32'(out_valid), 32'd0);
    end
  end

  task automatic send(input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    op_a     = a;
    op_b     = b;
    e        = model(a, b);
    e.due    = cyc + LAT;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a     = $urandom;
      op_b     = $urandom;
    end
  endtask

  function automatic logic [31:0] rand_op();
    int k;
    logic [7:0] e;
    k = $urandom_range(0, 19);
    if (k == 0)      e = 8'h00;
    else if (k == 1) e = 8'hFF;
    else if (k < 5)  e = 8'($urandom_range(1, 254));
    else             e = 8'($urandom_range(70, 184));
    if (k == 1 && $urandom_range(0, 1) == 0) return {1'($urandom), e, 23'd0};
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    // reset state: out_valid low (R2) is checked every cycle by the comparator
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R4: exact products, with and without the one-place normalization
    send(32'h3FC0_0000, 32'h4000_0000);   // 1.5 * 2.0
    send(32'h3F00_0000, 32'hBEE0_0000);   // 0.5 * -0.4375
    send(32'h3FC0_0000, 32'h3FC0_0000);   // 1.5 * 1.5
    send(32'hC0A0_0000, 32'h4040_0000);   // -5 * 3
    // R5: rounding, ties and carry-out
    send(32'h3F80_0001, 32'h3FC0_0000);
    send(32'h3F80_0001, 32'h3F80_0001);
    send(32'h3FFF_FFFF, 32'h3FFF_FFFF);
    send(32'h3F80_0003, 32'h3FC0_0000);
    // R6: overflow, including by rounding carry at the top exponent
    send(32'h7F00_0000, 32'hFF00_0000);
    send(32'h7F7F_FFFF, 32'h3F80_0001);
    send(32'h7F7F_FFFF, 32'h3F80_0000);   // stays finite
    // R7: underflow and the smallest normal result
    send(32'h0080_0000, 32'h0080_0000);
    send(32'h8080_0000, 32'h3F00_0000);
    send(32'h0080_0000, 32'h3F80_0000);
    // R8, R9, R10, R11: special operands
    send(32'h7F80_0000, 32'h0000_0000);
    send(32'h8000_0000, 32'hFF80_0000);
    send(32'h7FC0_0001, 32'h3F80_0000);
    send(32'h3F80_0000, 32'hFF80_0123);
    send(32'h0000_0123, 32'h4000_0000);   // exponent zero is zero (R10)
    send(32'h8000_0000, 32'h4040_0000);
    send(32'hFF80_0000, 32'hC000_0000);
    send(32'h7F80_0000, 32'h7F80_0000);
    send(32'h7F80_0000, 32'h0000_7777);   // inf * exponent-zero -> invalid (R8)
    idle(5);

    // R1: back-to-back and gapped traffic with mixed operands
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else send(rand_op(), rand_op());
    end
    idle(LAT + 3);

    n_checks++;
    if (q.size() != 0) begin
      n_fails++;
      $display("FAIL R1 results missing actual=%0d expected=0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule